// File: doc/BRIEF.md
# Quadrature DDS Carrier Generator

This block synthesizes a pair of carrier samples, a sine and a cosine at one shared frequency, from a single phase accumulator. Each time the sample-enable strobe is high, the accumulator adds a programmable step word and wraps around its width. The top bits of the new phase select one entry of a sinusoid table. A second entry, a quarter of the table further on, gives the cosine. Because both reads come from one phase value, the two outputs stay in exact quadrature at every frequency setting.

The table is computed as a constant while the design is elaborated, so no external memory file is needed. The output frequency is the step word times the sample rate divided by 2^16. A step of one gives the finest frequency resolution. A one-sample strobe marks each accumulator wrap, so a downstream modulator can line up symbol changes with carrier periods. The step word can change between any two samples.

Top module: `quad_dds`

## Requirements
- R1: While reset is high at a clock edge, the accumulator clears to phase 0. After that edge, sin_out is 0, cos_out is 127 and cycle_wrap is 0.
- R2: On each clock edge with smp_en high, the accumulator becomes (acc + step_word) mod 65536. The outputs that follow the edge reflect this new phase.
- R3: sin_out equals round(127·sin(2π·a/256)), where a is bits 15:8 of the accumulator after the update. Rounding is half away from zero and the value is two's complement.
- R4: cos_out equals the table value at address (a + 64) mod 256.
- R5: On a clock edge with smp_en low, the accumulator, sin_out and cos_out keep their values and cycle_wrap is 0.
- R6: cycle_wrap is 1 for exactly the sample whose addition carries out of bit 15, and 0 otherwise.
- R7: A new step_word is used by the first enabled sample edge at which it is present.
- R8: With step_word 0, the phase does not move and cycle_wrap never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; advances the phase |
| step_word | input | 16 | Phase increment per sample |
| sin_out | output | 8 | Signed sine sample |
| cos_out | output | 8 | Signed cosine sample |
| cycle_wrap | output | 1 | High for the sample on which the phase wraps |

## Verification
A step of 256 walks every table address exactly once. This tells apart wrong table entries and a wrong quarter offset for the cosine. Steps of 1 and of 0xFFFF test the lowest and highest increments: the first wraps rarely, the second wraps on nearly every sample, which exposes carry handling. An irregular step with a gated strobe separates true holding from free-running. A step word that changes on every sample, followed by a zero step, confirms that a new step takes effect at once and that a stopped phase never raises the wrap strobe.

// File: rtl/quad_dds.sv
module quad_dds #(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 8,
  parameter int AMP_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic [PHASE_W-1:0]      step_word,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] cos_out,
  output logic                    cycle_wrap
);
  localparam int  DEPTH = 1 << ADDR_W;
  localparam int  QTR   = DEPTH / 4;
  localparam real PEAK  = real'((1 << (AMP_W - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic signed [AMP_W-1:0] sample_at(input int k);
    real v;
    v = PEAK * $sin(TWO_PI * real'(k) / real'(DEPTH));
    if (v >= 0.0) return AMP_W'($rtoi(v + 0.5));
    else          return AMP_W'(-$rtoi(0.5 - v));
  endfunction

  logic signed [AMP_W-1:0] wave [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_wave
    localparam logic signed [AMP_W-1:0] VAL = sample_at(k);
    assign wave[k] = VAL;
  end

  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] nxt;
  logic               carry;
  logic [ADDR_W-1:0]  sin_a, cos_a;

  assign {carry, nxt} = {1'b0, acc} + {1'b0, step_word};
  assign sin_a = nxt[PHASE_W-1 -: ADDR_W];
  assign cos_a = sin_a + ADDR_W'(QTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      sin_out    <= wave[0];
      cos_out    <= wave[QTR];
      cycle_wrap <= 1'b0;
    end else if (smp_en) begin
      acc        <= nxt;
      sin_out    <= wave[sin_a];
      cos_out    <= wave[cos_a];
      cycle_wrap <= carry;
    end else begin
      cycle_wrap <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_dds_chk.sv
module quad_dds_chk #(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_en,
  input logic [PHASE_W-1:0]      step_word,
  input logic signed [AMP_W-1:0] sin_out,
  input logic signed [AMP_W-1:0] cos_out,
  input logic                    cycle_wrap
);
  int mag2;
  assign mag2 = int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out);

  a_r1_reset_phase: assert property (@(posedge clk)
    rst |=> (sin_out == 0 && cos_out == 127 && !cycle_wrap));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(sin_out) && $stable(cos_out) && !cycle_wrap));

  a_r6_wrap_needs_sample: assert property (@(posedge clk) disable iff (rst)
    cycle_wrap |-> $past(smp_en));

  a_r8_no_wrap_at_zero_step: assert property (@(posedge clk) disable iff (rst)
    (step_word == '0) |=> !cycle_wrap);

  a_r4_quadrature_radius: assert property (@(posedge clk) disable iff (rst)
    (mag2 > 15800 && mag2 < 16500));
endmodule

bind quad_dds quad_dds_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .step_word(step_word),
  .sin_out(sin_out), .cos_out(cos_out), .cycle_wrap(cycle_wrap)
);

// File: tb/sim_quad_dds.sv
module sim_quad_dds;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic [15:0] step_word = '0;
  logic signed [7:0] sin_out, cos_out;
  logic cycle_wrap;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_acc = '0;
  logic        m_wrap = 1'b0;

  always #4 clk = ~clk;

  quad_dds u0 (
    .clk(clk), .rst(rst), .smp_en(smp_en), .step_word(step_word),
    .sin_out(sin_out), .cos_out(cos_out), .cycle_wrap(cycle_wrap)
  );

  function automatic int ref_wave(input int a);
    real v;
    v = 127.0 * $sin(6.283185307179586 * real'(a) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(0.5 - v);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tag);
    int a;
    a = int'(m_acc[15:8]);
    check(tag, int'(sin_out), ref_wave(a));
    check("R4", int'(cos_out), ref_wave((a + 64) % 256));
    check("R6", int'(cycle_wrap), int'(m_wrap));
  endtask

  task automatic step(input logic en_i, input logic [15:0] inc_i, input string tag);
    logic [16:0] s;
    smp_en = en_i;
    step_word = inc_i;
    @(posedge clk);
    @(negedge clk);
    if (en_i) begin
      s = {1'b0, m_acc} + {1'b0, inc_i};
      m_acc = s[15:0];
      m_wrap = s[16];
    end else begin
      m_wrap = 1'b0;
    end
    check_outputs(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    smp_en = 1'b1;
    step_word = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_acc = '0;
    m_wrap = 1'b0;
    check("R1", int'(sin_out), 0);
    check("R1", int'(cos_out), 127);
    check("R1", int'(cycle_wrap), 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 256; i++) step(1'b1, 16'd256, "R3");
    for (int i = 0; i < 300; i++) step(1'b1, 16'd1, "R2");
    for (int i = 0; i < 40; i++) step(1'b1, 16'hFFFF, "R2");
    for (int i = 0; i < 600; i++) step((i % 3) != 0, 16'h1357, "R5");
    for (int i = 0; i < 400; i++) step(1'b1, 16'(i * 16'h0A31 + 7), "R7");
    for (int i = 0; i < 30; i++) step(1'b1, 16'd0, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 16'h4000, "R6");
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1, 16'h2000, "R2");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule